// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Engine

This block lets a processor fetch words from a serial NOR flash as if the flash were memory. Each accepted read request becomes one complete flash transaction on a single-lane SPI bus. The transaction has four phases in fixed order: an optional command byte, an address of zero to four bytes, a number of padding clocks that carry a chosen byte pattern, and 32 data clocks. One 32-bit format word selects which phases appear and what they carry. The four returned bytes are packed little-endian into a response word.

The engine is on after reset. A one-bit control write switches it off and hands the SPI pins to a software-driven controller. A transaction already under way when the engine is switched off still completes and delivers its response, and only then are the pins released. Requests and responses are valid/ready streams. A request is taken only in a cycle where `req_valid` and `req_ready` are both high. A response is held, unchanged, until `rsp_ready` takes it. Only one read is in flight at a time, so back-pressure on the response side stalls the request side.

Top module: `xip_flash_reader`

## Requirements
- R1: After reset the engine is enabled, `req_ready` is 1, `flash_cs_n` is 1 and `flash_sck` is 0.
- R2: SPI mode 0 is used. SCK rests low and each SCK half period lasts HALF_DIV clocks. MOSI changes only while SCK is low, and MISO is sampled on the rising edge. The phases run command, address, pad, data, each sent most significant bit first.
- R3: The command phase sends the code in format bits [23:16] over 8 clocks, and it is sent only when format bit 0 is 1.
- R4: Format bits [3:1] give the address length in bytes. A length of 0 skips the phase, and lengths above 4 send 4 bytes. The low bytes of `req_addr` are sent, most significant byte first.
- R5: Format bits [7:4] give the number of pad clocks, where 0 skips the phase. During the pad phase MOSI carries the pad code in bits [31:24], MSB first, restarting from its MSB every 8 clocks.
- R6: The data phase lasts 32 clocks with MOSI held at 0. The first byte received lands in `rsp_data[7:0]`, the fourth in `rsp_data[31:24]`, and each byte arrives MSB first.
- R7: `rsp_valid` rises in the same cycle that `flash_cs_n` returns high. While `rsp_ready` is 0 it stays high with `rsp_data` unchanged. No request is accepted while a transaction or a response is pending.
- R8: `flash_cs_n` is low in the cycle after the cycle in which a request is accepted.
- R9: While disabled, `req_ready` is 0 and the flash pins follow `sw_sck`, `sw_cs_n` and `sw_mosi`. Disabling during a transaction takes effect only after that transaction ends.
- R10: The lane-width fields in format bits [13:8] have no effect, and every code is served as single lane.
- R11: A control write with `ctrl_en_wdata`=1 re-enables the engine and takes the pins back, with `flash_cs_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Write strobe for the enable bit |
| ctrl_en_wdata | input | 1 | Enable value to write |
| fmt_cfg | input | 32 | Transaction format word |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Read request accepted when high with valid |
| req_addr | input | ADDR_W | Flash byte address |
| rsp_valid | output | 1 | Response word valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_data | output | 32 | Little-endian data word |
| sw_sck | input | 1 | Software controller SCK |
| sw_cs_n | input | 1 | Software controller chip select |
| sw_mosi | input | 1 | Software controller MOSI |
| flash_sck | output | 1 | SPI clock to flash |
| flash_cs_n | output | 1 | SPI chip select to flash |
| flash_mosi | output | 1 | SPI data to flash |
| flash_miso | input | 1 | SPI data from flash |

## Verification
Two things can land in the same stretch of cycles: a control write that clears the enable bit, and a read that is in progress. The bench provokes this by issuing a read, then clearing the enable bit while SCK is toggling. It judges the outcome on four points. The full flash sequence must still appear on the pins, and the response must carry the expected word. Only after chip select has risen may the pins mirror the software inputs. From then on `req_ready` must stay low until the enable bit is set again.

// File: rtl/xip_pkg.sv
package xip_pkg;

  localparam int WORD_BITS = 32;

  typedef enum logic [2:0] {
    PH_IDLE, PH_CMD, PH_ADDR, PH_PAD, PH_DATA, PH_DONE
  } phase_e;

  typedef struct packed {
    logic [7:0] pad_code;
    logic [7:0] cmd_code;
    logic [1:0] rsvd;
    logic [1:0] lane_data;
    logic [1:0] lane_addr;
    logic [1:0] lane_cmd;
    logic [3:0] pad_cnt;
    logic [2:0] addr_len;
    logic       cmd_en;
  } fmt_t;

  function automatic logic [2:0] eff_alen(input fmt_t f);
    return (f.addr_len > 3'd4) ? 3'd4 : f.addr_len;
  endfunction

  function automatic phase_e next_phase(input phase_e cur, input fmt_t f);
    phase_e n;
    n = PH_DONE;
    case (cur)
      PH_IDLE: n = f.cmd_en ? PH_CMD :
                   (f.addr_len != 3'd0) ? PH_ADDR :
                   (f.pad_cnt != 4'd0) ? PH_PAD : PH_DATA;
      PH_CMD:  n = (f.addr_len != 3'd0) ? PH_ADDR :
                   (f.pad_cnt != 4'd0) ? PH_PAD : PH_DATA;
      PH_ADDR: n = (f.pad_cnt != 4'd0) ? PH_PAD : PH_DATA;
      PH_PAD:  n = PH_DATA;
      default: n = PH_DONE;
    endcase
    return n;
  endfunction

  function automatic logic [5:0] phase_bits(input phase_e p, input fmt_t f);
    logic [5:0] n;
    case (p)
      PH_CMD:  n = 6'd8;
      PH_ADDR: n = {eff_alen(f), 3'b000};
      PH_PAD:  n = {2'b00, f.pad_cnt};
      PH_DATA: n = 6'd32;
      default: n = 6'd1;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/xip_sck_gen.sv
module xip_sck_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sck,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap     = run && (cnt == LAST);
  assign rise_stb = wrap && !sck;
  assign fall_stb = wrap && sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      sck <= ~sck;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/xip_seq.sv
module xip_seq
  import xip_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] start_addr,
  input  fmt_t        fmt,
  input  logic        rise_stb,
  input  logic        fall_stb,
  input  logic        miso,
  output logic        busy,
  output logic        cs_n,
  output logic        mosi,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_data
);
  phase_e      phase;
  fmt_t        fmt_q;
  logic [5:0]  bit_idx;
  logic [31:0] addr_sr;
  logic [31:0] cap;
  logic        last_bit;
  phase_e      nxt;
  logic [5:0]  shamt;

  assign busy     = (phase != PH_IDLE);
  assign cs_n     = !busy;
  assign last_bit = (bit_idx == phase_bits(phase, fmt_q) - 6'd1);
  assign nxt      = next_phase(phase, fmt_q);
  assign shamt    = 6'd32 - {eff_alen(fmt), 3'b000};
  assign rsp_data = cap;

  always_comb begin
    case (phase)
      PH_CMD:  mosi = fmt_q.cmd_code[~bit_idx[2:0]];
      PH_ADDR: mosi = addr_sr[31];
      PH_PAD:  mosi = fmt_q.pad_code[~bit_idx[2:0]];
      default: mosi = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      fmt_q     <= '0;
      bit_idx   <= '0;
      addr_sr   <= '0;
      cap       <= '0;
      rsp_valid <= 1'b0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      if (start) begin
        fmt_q   <= fmt;
        phase   <= next_phase(PH_IDLE, fmt);
        bit_idx <= '0;
        addr_sr <= start_addr << shamt;
      end else if (busy) begin
        if (rise_stb && phase == PH_DATA)
          cap[{bit_idx[4:3], ~bit_idx[2:0]}] <= miso;
        if (fall_stb) begin
          if (phase == PH_ADDR) addr_sr <= {addr_sr[30:0], 1'b0};
          if (last_bit) begin
            bit_idx <= '0;
            if (nxt == PH_DONE) begin
              phase     <= PH_IDLE;
              rsp_valid <= 1'b1;
            end else begin
              phase <= nxt;
            end
          end else begin
            bit_idx <= bit_idx + 6'd1;
          end
        end
      end
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R7
  AST_RSP_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $rose(cs_n)); // R7

endmodule

// File: rtl/xip_flash_reader.sv
module xip_flash_reader
  import xip_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              ctrl_en_wdata,
  input  logic [31:0]       fmt_cfg,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_data,
  input  logic              sw_sck,
  input  logic              sw_cs_n,
  input  logic              sw_mosi,
  output logic              flash_sck,
  output logic              flash_cs_n,
  output logic              flash_mosi,
  input  logic              flash_miso
);
  logic en_q;
  logic busy, eng_cs_n, eng_mosi, eng_sck, rise_stb, fall_stb;
  logic start, hw_own;
  logic [31:0] addr32;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= 1'b1;
    else if (ctrl_we) en_q <= ctrl_en_wdata;
  end

  assign req_ready = en_q && !busy && !rsp_valid;
  assign start     = req_valid && req_ready;
  assign addr32    = 32'(req_addr);

  xip_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_addr (addr32),
    .fmt        (fmt_t'(fmt_cfg)),
    .rise_stb   (rise_stb),
    .fall_stb   (fall_stb),
    .miso       (flash_miso),
    .busy       (busy),
    .cs_n       (eng_cs_n),
    .mosi       (eng_mosi),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_data   (rsp_data)
  );

  xip_sck_gen #(.HALF_DIV(HALF_DIV)) u_sck (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .sck      (eng_sck),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  assign hw_own     = en_q || busy;
  assign flash_sck  = hw_own ? eng_sck  : sw_sck;
  assign flash_cs_n = hw_own ? eng_cs_n : sw_cs_n;
  assign flash_mosi = hw_own ? eng_mosi : sw_mosi;

  AST_CS_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !flash_cs_n); // R8
  AST_SCK_REST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    eng_cs_n |-> !eng_sck); // R2
  AST_MOSI_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_sck && !eng_cs_n) |=> (!eng_sck || $stable(eng_mosi))); // R2

endmodule

// File: tb/test_xip_flash_reader.sv
module test_xip_flash_reader;
  localparam int HALF = 2;

  logic clk = 0, rst_n = 0;
  logic ctrl_we = 0, ctrl_en_wdata = 0;
  logic [31:0] fmt_cfg = 0;
  logic req_valid = 0, req_ready;
  logic [31:0] req_addr = 0;
  logic rsp_valid, rsp_ready = 0;
  logic [31:0] rsp_data;
  logic sw_sck = 0, sw_cs_n = 1, sw_mosi = 0;
  logic flash_sck, flash_cs_n, flash_mosi, flash_miso;

  int checks = 0, errors = 0, cyc = 0;
  int prev_rise = 0, last_rise = 0;

  // flash model state
  int rise_n = 0;
  int hdr_n = 0;
  logic [31:0] slave_word = 0;
  logic [0:127] rec;
  logic [0:127] exp_bits;

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  xip_flash_reader #(.ADDR_W(32), .HALF_DIV(HALF)) i_xip_flash_reader (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_en_wdata(ctrl_en_wdata),
    .fmt_cfg(fmt_cfg), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .sw_sck(sw_sck), .sw_cs_n(sw_cs_n), .sw_mosi(sw_mosi),
    .flash_sck(flash_sck), .flash_cs_n(flash_cs_n), .flash_mosi(flash_mosi),
    .flash_miso(flash_miso));

  always @(negedge flash_cs_n) rise_n = 0;
  always @(posedge flash_sck) begin
    if (!flash_cs_n) begin
      if (rise_n < 128) rec[rise_n] = flash_mosi;
      rise_n++;
      prev_rise = last_rise;
      last_rise = cyc;
    end
  end

  always @* begin
    int j;
    j = rise_n - hdr_n;
    if (j >= 0 && j < 32) flash_miso = slave_word[8*(j/8) + 7 - (j%8)];
    else flash_miso = 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // expected header from the format word (R2..R5)
  task automatic set_fmt(input logic [31:0] f, input logic [31:0] a);
    int al, n;
    fmt_cfg = f;
    n = 0;
    if (f[0]) for (int b = 7; b >= 0; b--) begin exp_bits[n] = f[16+b]; n++; end
    al = int'(f[3:1]);
    if (al > 4) al = 4;
    for (int b = 8*al-1; b >= 0; b--) begin exp_bits[n] = a[b]; n++; end
    for (int p = 0; p < int'(f[7:4]); p++) begin exp_bits[n] = f[24 + 7 - (p%8)]; n++; end
    hdr_n = n;
  endtask

  task automatic ctrl_write(input logic v);
    @(negedge clk); ctrl_we = 1; ctrl_en_wdata = v;
    @(negedge clk); ctrl_we = 0;
  endtask

  task automatic issue(input logic [31:0] a);
    @(negedge clk); req_valid = 1; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk); req_valid = 0;
    chk(flash_cs_n == 1'b0, "R8 cs low after accept", flash_cs_n, 0);
  endtask

  task automatic finish_read(input string tag, input logic [31:0] word);
    int bad;
    while (!rsp_valid) @(negedge clk);
    chk(flash_cs_n == 1'b1, "R7 cs high with rsp", flash_cs_n, 1);
    chk(rsp_data == word, {tag, " R6 data"}, rsp_data, word);
    chk(rise_n == hdr_n + 32, {tag, " R2 clock count"}, rise_n, hdr_n + 32);
    bad = 0;
    for (int i = 0; i < hdr_n; i++) if (rec[i] !== exp_bits[i]) bad++;
    chk(bad == 0, {tag, " header bits"}, bad, 0);
    bad = 0;
    for (int i = hdr_n; i < hdr_n + 32; i++) if (rec[i] !== 1'b0) bad++;
    chk(bad == 0, "R6 mosi low in data", bad, 0);
    rsp_ready = 1; @(negedge clk); rsp_ready = 0;
  endtask

  task automatic read_one(input string tag, input logic [31:0] f, input logic [31:0] a,
                          input logic [31:0] word);
    set_fmt(f, a);
    slave_word = word;
    issue(a);
    finish_read(tag, word);
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk(flash_cs_n == 1'b1, "R1 cs_n", flash_cs_n, 1);
    chk(flash_sck == 1'b0, "R1 sck", flash_sck, 0);
  endtask

  task automatic t_basic();
    read_one("R3 R4 basic", 32'h0003_0007, 32'h0012_3456, 32'hDEAD_BEEF);
    chk(last_rise - prev_rise == 2*HALF, "R2 sck period", last_rise - prev_rise, 2*HALF);
  endtask

  task automatic t_pad();
    read_one("R5 pad wrap", 32'hA50B_00A9, 32'h89AB_CDEF, 32'h0102_0304);
  endtask

  task automatic t_nocmd();
    read_one("R3 no cmd", 32'h0077_0006, 32'h00F0_0F55, 32'h8000_0001);
  endtask

  task automatic t_noaddr();
    read_one("R4 no addr", 32'h00C3_0001, 32'hFFFF_FFFF, 32'h55AA_33CC);
    read_one("R4 len clamp", 32'h0013_000D, 32'h1357_9BDF, 32'hCAFE_F00D);
  endtask

  task automatic t_proto();
    read_one("R10 lanes", 32'h3C6B_2A37, 32'h0001_0203, 32'h7E81_4224);
  endtask

  task automatic t_backpressure();
    logic [31:0] held;
    set_fmt(32'h0003_0007, 32'h0000_0100);
    slave_word = 32'h600D_1DEA;
    issue(32'h0000_0100);
    while (!rsp_valid) @(negedge clk);
    held = rsp_data;
    @(negedge clk); req_valid = 1;
    repeat (6) @(negedge clk);
    chk(rsp_valid == 1'b1, "R7 valid held", rsp_valid, 1);
    chk(rsp_data == held, "R7 data stable", rsp_data, held);
    chk(req_ready == 1'b0, "R7 no accept while pending", req_ready, 0);
    chk(flash_cs_n == 1'b1, "R7 no new transfer", flash_cs_n, 1);
    req_valid = 0;
    finish_read("R7 after stall", 32'h600D_1DEA);
  endtask

  task automatic t_disable();
    ctrl_write(0);
    chk(req_ready == 1'b0, "R9 ready low when off", req_ready, 0);
    sw_sck = 1; sw_cs_n = 0; sw_mosi = 1;
    @(negedge clk);
    chk({flash_sck, flash_cs_n, flash_mosi} == 3'b101, "R9 pins follow sw",
        {flash_sck, flash_cs_n, flash_mosi}, 3'b101);
    req_valid = 1;
    repeat (4) @(negedge clk);
    chk(rsp_valid == 1'b0, "R9 no read when off", rsp_valid, 0);
    req_valid = 0; sw_sck = 0; sw_cs_n = 1; sw_mosi = 0;
    ctrl_write(1);
    chk(req_ready == 1'b1, "R11 re-enabled", req_ready, 1);
    chk(flash_cs_n == 1'b1, "R11 engine owns cs", flash_cs_n, 1);
  endtask

  task automatic t_midoff();
    set_fmt(32'h0003_0007, 32'h00AB_CDEF);
    slave_word = 32'h1234_5678;
    issue(32'h00AB_CDEF);
    repeat (20) @(negedge clk);
    sw_cs_n = 1; sw_sck = 1; sw_mosi = 1;
    ctrl_write(0);
    chk(flash_cs_n == 1'b0, "R9 transfer kept", flash_cs_n, 0);
    finish_read("R9 mid-off", 32'h1234_5678);
    sw_cs_n = 0;
    @(negedge clk);
    chk({flash_sck, flash_cs_n, flash_mosi} == 3'b101, "R9 released after end",
        {flash_sck, flash_cs_n, flash_mosi}, 3'b101);
    chk(req_ready == 1'b0, "R9 ready low after end", req_ready, 0);
    sw_cs_n = 1; sw_sck = 0; sw_mosi = 0;
    ctrl_write(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R7 response never arrived");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_pad();
    t_nocmd();
    t_noaddr();
    t_proto();
    t_backpressure();
    t_disable();
    t_midoff();
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule